// File: doc/BRIEF.md
# Serial Line Bit Path with Loopbacks

This block is the bit-level data path of a byte-wide optical line interface. It runs on a single bit clock and derives a byte strobe from it by dividing by eight. At every byte boundary it captures a parallel transmit byte. It then shifts that byte onto the serial line output, most significant bit first, one bit per clock.

On the receive side it selects the single bit stream that feeds the downstream framer. In normal operation that stream is the line input, which is forced to zero while loss of signal is high. When terminal loopback is selected, the stream is the block's own serializer output instead. When facility loopback is selected, the (gated) line input is sent back out on the line output in place of the serializer. The two loopback selects are active low and work independently of each other.

A small tracking state machine drives the lock-detect flag. Its states are LK_RESET (entered on reset), LK_TRACK (signal present) and LK_DARK (signal lost). Its transitions are:
- LK_RESET to LK_TRACK when loss of signal is low.
- LK_RESET to LK_DARK when loss of signal is high.
- LK_TRACK to LK_DARK when loss of signal rises.
- LK_DARK to LK_TRACK when loss of signal falls.

Top module: `line_bitpath`

## Requirements
- R1: While `rst_n` is low, `byte_stb` is 0, `lock_det` is 0, and `line_tx_bit` is 0 when `fac_lb_n` is 1.
- R2: `byte_stb` is high for exactly one clock in every eight. It is first high in the cycle after the 7th rising edge that follows reset release.
- R3: The rising edge that ends a `byte_stb` cycle captures `tx_byte`. Bit 7 of that byte is the serializer output in the following cycle, then bits 6 down to 0 follow on successive cycles. The next byte's bit 7 follows bit 0 with no gap.
- R4: With `term_lb_n` = 1 and `los` = 0, `rx_bit` equals `line_rx_bit` in the same cycle.
- R5: With `term_lb_n` = 0, `rx_bit` equals the serializer output, whatever `line_rx_bit` and `los` are.
- R6: With `term_lb_n` = 1 and `los` = 1, `rx_bit` is 0.
- R7: With `fac_lb_n` = 1, `line_tx_bit` carries the serializer output.
- R8: With `fac_lb_n` = 0, `line_tx_bit` carries `line_rx_bit` gated by loss of signal (0 while `los` = 1).
- R9: Both loopbacks may be active at once. `rx_bit` then carries the serializer bit stream and, in the same cycles, `line_tx_bit` carries the gated line input.
- R10: `lock_det` rises at the first rising edge that samples `los` low after reset. It falls in the same cycle that `los` rises and stays low while `los` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| tx_byte | input | 8 | Parallel transmit byte, bit 7 sent first |
| line_rx_bit | input | 1 | Serial bit from the line |
| los | input | 1 | Loss of signal, active high |
| term_lb_n | input | 1 | Terminal loopback select, active low |
| fac_lb_n | input | 1 | Facility loopback select, active low |
| byte_stb | output | 1 | Byte strobe, one clock in eight |
| line_tx_bit | output | 1 | Serial bit to the line |
| rx_bit | output | 1 | Serial bit to the framer |
| lock_det | output | 1 | Lock-detect flag |

## Verification
Terminal and facility loopback can be in effect in the same cycle. The serializer then reaches the receive output while the line input reaches the line output. The bench provokes this by pulling both selects low and holding the line input at 1 while a known byte (0x3C) is serialized. In every one of the eight bit cycles it checks `rx_bit` against the expected bit of the byte and `line_tx_bit` against the line level. A vector table also covers all sixteen combinations of the two selects, loss of signal and line level, with the serializer held at a constant 1.

// File: rtl/lbp_pkg.sv
package lbp_pkg;

    typedef enum logic [1:0] {
        LK_RESET = 2'd0,
        LK_TRACK = 2'd1,
        LK_DARK  = 2'd2
    } lock_state_t;

endpackage

// File: rtl/lbp_byte_ctr.sv
module lbp_byte_ctr #(
    parameter int BYTE_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic stb
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= '0;
        else if (phase_q == LAST)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    assign stb = (phase_q == LAST);

    // R2
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> !stb);

endmodule

// File: rtl/lbp_serializer.sv
module lbp_serializer #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              ser_bit
);
    logic [BYTE_W-1:0] shreg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            shreg_q <= '0;
        else if (load)
            shreg_q <= byte_in;
        else
            shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
    end

    assign ser_bit = shreg_q[BYTE_W-1];

    // R3
    msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ser_bit == $past(byte_in[BYTE_W-1])));

endmodule

// File: rtl/lbp_rx_select.sv
module lbp_rx_select (
    input  logic line_rx_bit,
    input  logic los,
    input  logic term_lb_n,
    input  logic fac_lb_n,
    input  logic ser_bit,
    output logic rx_bit,
    output logic line_tx_bit
);
    logic gated_rx;

    always_comb begin
        gated_rx    = line_rx_bit & ~los;
        rx_bit      = term_lb_n ? gated_rx : ser_bit;
        line_tx_bit = fac_lb_n  ? ser_bit  : gated_rx;
    end

endmodule

// File: rtl/lbp_lock_fsm.sv
module lbp_lock_fsm
    import lbp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic los,
    output logic lock_det
);
    lock_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= LK_RESET;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_RESET: state_d = los ? LK_DARK : LK_TRACK;
            LK_TRACK: if (los)  state_d = LK_DARK;
            LK_DARK:  if (!los) state_d = LK_TRACK;
            default:  state_d = LK_RESET;
        endcase
    end

    always_comb begin
        lock_det = (state_q == LK_TRACK) && !los;
    end

    // R10
    lock_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !los |=> (los || lock_det));

endmodule

// File: rtl/line_bitpath.sv
module line_bitpath #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              line_rx_bit,
    input  logic              los,
    input  logic              term_lb_n,
    input  logic              fac_lb_n,
    output logic              byte_stb,
    output logic              line_tx_bit,
    output logic              rx_bit,
    output logic              lock_det
);
    logic ser_bit;

    lbp_byte_ctr #(.BYTE_W(BYTE_W)) ctr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (byte_stb)
    );

    lbp_serializer #(.BYTE_W(BYTE_W)) ser_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (byte_stb),
        .byte_in (tx_byte),
        .ser_bit (ser_bit)
    );

    lbp_rx_select sel_i (
        .line_rx_bit (line_rx_bit),
        .los         (los),
        .term_lb_n   (term_lb_n),
        .fac_lb_n    (fac_lb_n),
        .ser_bit     (ser_bit),
        .rx_bit      (rx_bit),
        .line_tx_bit (line_tx_bit)
    );

    lbp_lock_fsm lock_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .los      (los),
        .lock_det (lock_det)
    );

    // R6
    los_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (term_lb_n && los) |-> !rx_bit);

    // R5
    term_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !term_lb_n |-> (rx_bit == ser_bit));

    // R8
    fac_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fac_lb_n && los) |-> !line_tx_bit);

endmodule

// File: tb/line_bitpath_tb.sv
module line_bitpath_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] tx_byte;
    logic       line_rx_bit, los, term_lb_n, fac_lb_n;
    logic       byte_stb, line_tx_bit, rx_bit, lock_det;

    int n_checks = 0;
    int n_errors = 0;

    // Stimulus bits [5:2] = {term_lb_n, fac_lb_n, los, line_rx_bit};
    // expected bits [1:0] = {rx_bit, line_tx_bit}, serializer held at 1
    localparam logic [5:0] VEC [16] = '{
        6'b0000_10, 6'b0001_11, 6'b0010_10, 6'b0011_10,
        6'b0100_11, 6'b0101_11, 6'b0110_11, 6'b0111_11,
        6'b1000_00, 6'b1001_11, 6'b1010_00, 6'b1011_00,
        6'b1100_01, 6'b1101_11, 6'b1110_01, 6'b1111_01
    };

    always #5 clk = ~clk;

    line_bitpath dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_byte     (tx_byte),
        .line_rx_bit (line_rx_bit),
        .los         (los),
        .term_lb_n   (term_lb_n),
        .fac_lb_n    (fac_lb_n),
        .byte_stb    (byte_stb),
        .line_tx_bit (line_tx_bit),
        .rx_bit      (rx_bit),
        .lock_det    (lock_det)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_stb();
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); #2;
            if (byte_stb) break;
        end
    endtask

    initial begin
        #1_000_000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int edges;
        rst_n = 1'b0; tx_byte = 8'hA5; line_rx_bit = 1'b0; los = 1'b0;
        term_lb_n = 1'b1; fac_lb_n = 1'b1;
        repeat (3) @(negedge clk);
        #2;
        check("R1 stb", byte_stb, 1'b0);
        check("R1 lock", lock_det, 1'b0);
        check("R1 tx", line_tx_bit, 1'b0);

        // R2: first strobe after the 7th edge following release
        @(negedge clk); rst_n = 1'b1;
        edges = 0;
        for (int k = 0; k < 12; k++) begin
            @(posedge clk); #2; edges++;
            if (byte_stb) break;
        end
        check("R2 first", (edges == 7), 1'b1);
        // R10: lock after first edge sampling los low
        check("R10 rise", lock_det, 1'b1);
        // R3 / R7: A5 serialized MSB first
        for (int b = 7; b >= 0; b--) begin
            @(posedge clk); #2;
            check("R3/R7 bit", line_tx_bit, tx_byte[b]);
            if (b > 0) check("R2 gap", byte_stb, 1'b0);
        end
        check("R2 period", byte_stb, 1'b1);

        // Vector table with serializer held at constant 1
        tx_byte = 8'hFF;
        wait_stb();
        @(posedge clk);
        for (int v = 0; v < 16; v++) begin
            @(negedge clk);
            {term_lb_n, fac_lb_n, los, line_rx_bit} = VEC[v][5:2];
            #2;
            if (!term_lb_n)  check("R5 rx", rx_bit, VEC[v][1]);
            else if (los)    check("R6 rx", rx_bit, VEC[v][1]);
            else             check("R4 rx", rx_bit, VEC[v][1]);
            if (fac_lb_n)    check("R7 tx", line_tx_bit, VEC[v][0]);
            else             check("R8 tx", line_tx_bit, VEC[v][0]);
        end

        // R9: both loopbacks, byte 3C on rx while line level on tx
        @(negedge clk);
        los = 1'b0; line_rx_bit = 1'b1; term_lb_n = 1'b0; fac_lb_n = 1'b0;
        tx_byte = 8'h3C;
        wait_stb();
        for (int b = 7; b >= 0; b--) begin
            @(posedge clk); #2;
            check("R9 rx", rx_bit, tx_byte[b]);
            check("R9 tx", line_tx_bit, 1'b1);
        end

        // R10: lock falls same cycle los rises, returns one edge after
        @(negedge clk); term_lb_n = 1'b1; fac_lb_n = 1'b1;
        #2; check("R10 held", lock_det, 1'b1);
        @(negedge clk); los = 1'b1;
        #1; check("R10 fall", lock_det, 1'b0);
        @(posedge clk); #2; check("R10 low", lock_det, 1'b0);
        @(negedge clk); los = 1'b0;
        #2; check("R10 wait", lock_det, 1'b0);
        @(posedge clk); #2; check("R10 back", lock_det, 1'b1);

        // R1: asynchronous reset mid-run
        @(negedge clk); rst_n = 1'b0;
        #2;
        check("R1 async lock", lock_det, 1'b0);
        check("R1 async stb", byte_stb, 1'b0);
        check("R1 async tx", line_tx_bit, 1'b0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule